// File: doc/BRIEF.md
# Serial Register Slave for a Clock Generator

This block lets a host on a two-wire serial bus read and write a small bank of 8-bit control registers inside a clock generator. The serial clock and data lines are sampled with a much faster system clock. START and STOP conditions are recovered from the sampled lines. The slave answers only to its own 7-bit address.

After the address, the host sends a command code. Bit 7 of that code picks the transfer type:

- **Bit 7 = 1:** a single-byte access at the 7-bit offset in bits 6:0.
- **Bit 7 = 0:** a block access that always starts at register 0.

The slave drives the data line only through an open-drain enable, which pulls the line low.

Four registers are implemented, each loaded with a default at reset. Their writable bits leave the block as control outputs. A few bit positions are not stored at all: they return live input-pin levels when read, and writes to them are dropped. A mode input turns on an alternate block-write form that has no byte-count byte.

Top module: `ckgen_regif_slave`

## Requirements
- R1: The slave acknowledges every byte while it is addressed with 7-bit address 1101001 (0xD2 write, 0xD3 read). Any other address gets no acknowledge, and the slave stays off the bus and changes nothing until the next START.
- R2: Byte write: address 0xD2, then a command code with bit 7 = 1 and the offset in bits 6:0, then one data byte. The data byte is stored at that offset.
- R3: Byte read: a command code with bit 7 = 1, a repeated START, address 0xD3, one byte returned MSB first, a master NACK, then STOP. The returned byte is the register at the offset.
- R4: Block write: command code 0x00, a byte-count byte (its value is not used), then data bytes. The data bytes are stored into registers 0, 1, 2, 3 in that order.
- R5: Block read: command code 0x00, a repeated START, address 0xD3. The slave returns the byte count 4, then registers 0, 1, 2, 3 in order, and keeps going for as long as the master acknowledges.
- R6: A STOP after any complete byte ends the transfer. Data bytes that were already acknowledged stay written.
- R7: At reset the register values are 0x00, 0x07, 0x7F and 0xC7 (registers 0 to 3). They appear on `ctrl_q` with register n in bits 8n+7:8n.
- R8: Some bits read back live pin values and are not stored:
  - register 0 bit 4 = `pin_cpu_stop`
  - register 0 bits 2:0 = `pin_fsel`
  - register 1 bit 7 = `pin_mult`

  Writes to these bits are ignored, and they read as 0 on `ctrl_q`. The writable masks are 0xE8, 0x7F, 0xFF and 0xFF for registers 0 to 3.
- R9: With `i2c_mode` = 1, a block write has no byte-count byte: the data bytes follow the command code directly.
- R10: The slave drives SDA low only through `sda_oe` = 1. `sda_oe` changes only while SCL is low, and it is 0 whenever the bus is idle.
- R11: A write to an offset of 4 or more changes nothing. A read at an offset of 4 or more, including block-read bytes past register 3, returns 0x00.
- R12: A START in the middle of a byte restarts address decoding. The transfer that follows completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| i2c_mode | input | 1 | 1 = block write without byte-count byte |
| pin_cpu_stop | input | 1 | Live pin shown in register 0 bit 4 |
| pin_fsel | input | 3 | Live pins shown in register 0 bits 2:0 |
| pin_mult | input | 1 | Live pin shown in register 1 bit 7 |
| ctrl_q | output | 32 | Stored writable register bits, register n at bits 8n+7:8n |

## Verification
A behavioural register model in the bench is compared with `ctrl_q` on every clock between transfers. Each transfer form is tried on its own:

- byte and block writes with distinct data;
- block writes that are cut short by STOP, and block writes with the count byte skipped;
- byte reads and over-long block reads;
- a foreign address;
- an out-of-range offset;
- a START injected halfway through a command byte.

The data values are chosen to tell apart the following faults:

- a wrong starting index;
- a missed or extra count byte;
- a mask that lets read-only bits through;
- a lost write on early STOP.

Changing the pin levels between two reads shows that the read-only bits are live.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } rx_ph_e;

  // Power-up value of each register (writable bits only are kept)
  function automatic logic [7:0] reg_reset_val(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      default: return 8'h00;
    endcase
  endfunction

  // Bits that are stored; the rest come from pins
  function automatic logic [7:0] reg_wr_mask(input int idx);
    case (idx)
      0:       return 8'hE8;
      1:       return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smbr_line_sync.sv
module smbr_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES:0] scl_pipe_q;
  logic [SYNC_STAGES:0] sda_pipe_q;
  logic                 scl_d;
  logic                 sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-1:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s = sda_pipe_q[SYNC_STAGES-1];
  assign scl_d = scl_pipe_q[SYNC_STAGES];
  assign sda_d = sda_pipe_q[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smbr_regbank.sv
module smbr_regbank
  import smbr_pkg::*;
#(
  parameter int NREG = 4,
  parameter int IDXW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDXW-1:0]   rd_idx,
  input  logic              pin_cpu_stop,
  input  logic [2:0]        pin_fsel,
  input  logic              pin_mult,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] ctrl_q
);

  logic [7:0] store_q [NREG];
  logic [7:0] live    [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] WMASK = reg_wr_mask(g);
    localparam logic [7:0] RSTV  = reg_reset_val(g) & WMASK;
    logic hit;

    assign hit = wr_en && (wr_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q[g] <= RSTV;
      end else if (hit) begin
        store_q[g] <= wr_data & WMASK;
      end
    end

    assign ctrl_q[g*8 +: 8] = store_q[g];

    if (g == 0) begin : g_live0
      assign live[g] = {3'b000, pin_cpu_stop, 1'b0, pin_fsel};
    end else if (g == 1) begin : g_live1
      assign live[g] = {pin_mult, 7'b0000000};
    end else begin : g_nolive
      assign live[g] = 8'h00;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDXW'(i)) rd_data = store_q[i] | live[i];
    end
  end

  // R11
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= IDXW'(NREG))) |=> $stable(ctrl_q));

endmodule

// File: rtl/ckgen_regif_slave.sv
module ckgen_regif_slave
  import smbr_pkg::*;
#(
  parameter int          NREG        = 4,
  parameter logic [6:0]  SLV_ADDR    = 7'h69,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              i2c_mode,
  input  logic              pin_cpu_stop,
  input  logic [2:0]        pin_fsel,
  input  logic              pin_mult,
  output logic [NREG*8-1:0] ctrl_q
);

  localparam int         IDXW    = 7;
  localparam logic [7:0] CNT_VAL = 8'(NREG);

  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  smbr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  bus_st_e         st_q, st_d;
  rx_ph_e          ph_q, ph_d;
  logic [3:0]      bit_q, bit_d;
  logic [7:0]      sh_q, sh_d;
  logic [7:0]      tx_q, tx_d;
  logic [IDXW-1:0] ptr_q, ptr_d;
  logic            cnt_pend_q, cnt_pend_d;
  logic            tx_next_q, tx_next_d;
  logic            oe_q, oe_d;
  logic            wr_en, tx_load;
  logic [7:0]      rd_data, tx_byte;

  smbr_regbank #(.NREG(NREG), .IDXW(IDXW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_ni),
    .wr_en        (wr_en),
    .wr_idx       (ptr_q),
    .wr_data      (sh_q),
    .rd_idx       (ptr_q),
    .pin_cpu_stop (pin_cpu_stop),
    .pin_fsel     (pin_fsel),
    .pin_mult     (pin_mult),
    .rd_data      (rd_data),
    .ctrl_q       (ctrl_q)
  );

  assign tx_byte = cnt_pend_q ? CNT_VAL : rd_data;

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    tx_d       = tx_q;
    ptr_d      = ptr_q;
    cnt_pend_d = cnt_pend_q;
    tx_next_d  = tx_next_q;
    oe_d       = oe_q;
    wr_en      = 1'b0;
    tx_load    = 1'b0;

    if (start_det) begin
      st_d  = ST_RX;
      ph_d  = PH_ADDR;
      bit_d = 4'd0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d  = ST_IDLE;
      bit_d = 4'd0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && (bit_q == 4'd8)) begin
            st_d      = ST_RACK;
            oe_d      = 1'b1;
            tx_next_d = 1'b0;
            case (ph_q)
              PH_ADDR: begin
                if (sh_q[7:1] == SLV_ADDR) begin
                  if (sh_q[0]) tx_next_d = 1'b1;
                  else         ph_d      = PH_CMD;
                end else begin
                  st_d = ST_SKIP;
                  oe_d = 1'b0;
                end
              end
              PH_CMD: begin
                if (sh_q[7]) begin
                  ptr_d      = sh_q[6:0];
                  cnt_pend_d = 1'b0;
                  ph_d       = PH_DATA;
                end else begin
                  ptr_d      = '0;
                  cnt_pend_d = 1'b1;
                  ph_d       = i2c_mode ? PH_DATA : PH_CNT;
                end
              end
              PH_CNT: ph_d = PH_DATA;
              default: begin
                wr_en = 1'b1;
                if (ptr_q != '1) ptr_d = ptr_q + 1'b1;
              end
            endcase
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            bit_d = 4'd0;
            if (tx_next_q) begin
              tx_load = 1'b1;
              st_d    = ST_TX;
            end else begin
              st_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d = 1'b0;
              st_d = ST_TACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            if (sda_s) st_d = ST_SKIP;
          end else if (scl_fall) begin
            bit_d   = 4'd0;
            tx_load = 1'b1;
            st_d    = ST_TX;
          end
        end
        default: ;
      endcase
    end

    if (tx_load) begin
      tx_d = tx_byte;
      oe_d = ~tx_byte[7];
      if (cnt_pend_q)        cnt_pend_d = 1'b0;
      else if (ptr_q != '1)  ptr_d      = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_ADDR;
      bit_q      <= 4'd0;
      sh_q       <= 8'h00;
      tx_q       <= 8'h00;
      ptr_q      <= '0;
      cnt_pend_q <= 1'b0;
      tx_next_q  <= 1'b0;
      oe_q       <= 1'b0;
    end else begin
      st_q       <= st_d;
      ph_q       <= ph_d;
      bit_q      <= bit_d;
      sh_q       <= sh_d;
      tx_q       <= tx_d;
      ptr_q      <= ptr_d;
      cnt_pend_q <= cnt_pend_d;
      tx_next_q  <= tx_next_d;
      oe_q       <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((st_q == ST_IDLE) || (st_q == ST_SKIP)) |-> !oe_q);

  // R10
  oe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(oe_q));

  // R1
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_RACK) |-> oe_q);

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_det |=> ((st_q == ST_RX) && (ph_q == PH_ADDR) && (bit_q == 4'd0)));

  // R4
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> ((st_q == ST_RACK) && oe_q));

endmodule

// File: tb/ckgen_regif_slave_tb.sv
module ckgen_regif_slave_tb;

  localparam int NREG = 4;
  localparam int Q    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       i2c_mode = 1'b0;
  logic       cpu_stop = 1'b0;
  logic       mult = 1'b0;
  logic [2:0] fsel = 3'b000;
  wire              sda_oe;
  wire [NREG*8-1:0] ctrl_q;
  wire              sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  ckgen_regif_slave u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .sda_oe       (sda_oe),
    .i2c_mode     (i2c_mode),
    .pin_cpu_stop (cpu_stop),
    .pin_fsel     (fsel),
    .pin_mult     (mult),
    .ctrl_q       (ctrl_q)
  );

  int         errs = 0;
  int         checks = 0;
  bit         chk_en = 1'b0;
  bit         done = 1'b0;
  logic       oe_prev = 1'b0;
  logic [7:0] m  [NREG];
  logic [7:0] bw [NREG];

  function automatic logic [7:0] wmask(input int i);
    case (i)
      0:       return 8'hE8;
      1:       return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int i);
    logic [7:0] lv;
    lv = 8'h00;
    if (i == 0) lv = {3'b000, cpu_stop, 1'b0, fsel};
    if (i == 1) lv = {mult, 7'b0000000};
    if (i < NREG) return (m[i] & wmask(i)) | lv;
    return 8'h00;
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // per-clock model compare between transfers
  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      checks++;
      if (ctrl_q !== {m[3], m[2], m[1], m[0]}) begin
        errs++;
        $display("FAIL R6 ctrl_q actual=%h expected=%h", ctrl_q, {m[3], m[2], m[1], m[0]});
      end
    end
  end

  // R10: sda_oe edges only while SCL low
  always @(negedge clk) begin
    if (sda_oe !== oe_prev) begin
      checks++;
      if (scl_m !== 1'b0) begin
        errs++;
        $display("FAIL R10 sda_oe moved with scl actual=%b expected=0", scl_m);
      end
    end
    oe_prev = sda_oe;
  end

  task automatic bus_start;
    chk_en = 1'b0;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
    checks++;
    if (sda_oe !== 1'b0) begin
      errs++;
      $display("FAIL R10 idle sda_oe actual=%b expected=0", sda_oe);
    end
    chk_en = 1'b1;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wack(input string tag, input logic [7:0] b, input logic exp);
    logic a;
    wbyte(b, a);
    chk8(tag, {7'd0, a}, {7'd0, exp});
  endtask

  task automatic reg_write(input string tag, input logic [6:0] off, input logic [7:0] d);
    bus_start;
    wack("R1 addr ack", 8'hD2, 1'b1);
    wack(tag, {1'b1, off}, 1'b1);
    wack(tag, d, 1'b1);
    if (off < NREG) m[off] = d & wmask(int'(off));
    bus_stop;
  endtask

  task automatic reg_read(input string tag, input logic [6:0] off);
    logic [7:0] d;
    bus_start;
    wack("R1 addr ack", 8'hD2, 1'b1);
    wack(tag, {1'b1, off}, 1'b1);
    bus_start;
    wack("R1 raddr ack", 8'hD3, 1'b1);
    rbyte(1'b0, d);
    bus_stop;
    chk8(tag, d, exp_rd(int'(off)));
  endtask

  task automatic blk_write(input string tag, input bit with_cnt, input int n);
    bus_start;
    wack("R1 addr ack", 8'hD2, 1'b1);
    wack(tag, 8'h00, 1'b1);
    if (with_cnt) wack(tag, 8'h04, 1'b1);
    for (int i = 0; i < n; i++) begin
      wack(tag, bw[i], 1'b1);
      m[i] = bw[i] & wmask(i);
    end
    bus_stop;
  endtask

  task automatic blk_read(input int n);
    logic [7:0] d;
    bus_start;
    wack("R1 addr ack", 8'hD2, 1'b1);
    wack("R5 cmd ack", 8'h00, 1'b1);
    bus_start;
    wack("R1 raddr ack", 8'hD3, 1'b1);
    rbyte(1'b1, d);
    chk8("R5 count", d, 8'h04);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk8(i >= NREG ? "R11 blk past end" : "R5 blk data", d, exp_rd(i));
    end
    bus_stop;
  endtask

  initial begin
    m[0] = 8'h00; m[1] = 8'h07; m[2] = 8'h7F; m[3] = 8'hC7;
    tick(10);
    rst_n = 1'b1;
    tick(6);
    // R7 reset state
    chk8("R7 reg0", ctrl_q[7:0], 8'h00);
    chk8("R7 reg1", ctrl_q[15:8], 8'h07);
    chk8("R7 reg2", ctrl_q[23:16], 8'h7F);
    chk8("R7 reg3", ctrl_q[31:24], 8'hC7);
    chk_en = 1'b1;

    // R3 byte read of defaults
    reg_read("R3 read reg3", 7'd3);
    reg_read("R3 read reg2", 7'd2);

    // R2 byte write and readback
    reg_write("R2 write reg2", 7'd2, 8'h55);
    reg_read("R2 readback reg2", 7'd2);

    // R8 live pins and masked writes
    cpu_stop = 1'b1; fsel = 3'b101; mult = 1'b1;
    reg_write("R8 write reg0", 7'd0, 8'hFF);
    reg_read("R8 read reg0", 7'd0);
    reg_write("R8 write reg1", 7'd1, 8'hFF);
    reg_read("R8 read reg1", 7'd1);
    cpu_stop = 1'b0; fsel = 3'b010; mult = 1'b0;
    reg_read("R8 live reg0", 7'd0);
    reg_read("R8 live reg1", 7'd1);

    // R4 full block write
    bw[0] = 8'h9F; bw[1] = 8'h34; bw[2] = 8'h56; bw[3] = 8'h78;
    blk_write("R4 block write", 1'b1, 4);

    // R5 / R11 block read beyond the end
    blk_read(6);

    // R1 foreign address
    bus_start;
    wack("R1 foreign addr", 8'hA0, 1'b0);
    wack("R1 foreign cmd", 8'h82, 1'b0);
    wack("R1 foreign data", 8'h11, 1'b0);
    bus_stop;
    reg_read("R1 reg2 untouched", 7'd2);

    // R6 early stop in block write
    bw[0] = 8'hE0; bw[1] = 8'h22;
    blk_write("R6 partial block", 1'b1, 2);
    reg_read("R6 reg0", 7'd0);
    reg_read("R6 reg1", 7'd1);
    reg_read("R6 reg2 kept", 7'd2);

    // R9 block write with no count byte
    i2c_mode = 1'b1;
    bw[0] = 8'h5A; bw[1] = 8'hA5; bw[2] = 8'h0F;
    blk_write("R9 no-count block", 1'b0, 3);
    i2c_mode = 1'b0;
    reg_read("R9 reg2", 7'd2);

    // R11 out-of-range offset
    reg_write("R11 write oob", 7'h10, 8'hAA);
    reg_read("R11 read oob", 7'h10);

    // R12 start in the middle of a command byte
    bus_start;
    wack("R12 addr ack", 8'hD2, 1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_start;
    wack("R12 re-addr ack", 8'hD2, 1'b1);
    wack("R12 cmd ack", 8'h81, 1'b1);
    wack("R12 data ack", 8'h3C, 1'b1);
    m[1] = 8'h3C & wmask(1);
    bus_stop;
    reg_read("R12 readback", 7'd1);

    tick(20);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule